// File: doc/BRIEF.md
# Three-Wire Timekeeper Burst Master

This block drives a serial real-time-clock device over three wires. The wires are an enable line that holds the device in reset while low, a serial clock, and one bidirectional data line. The host starts a read with a one-cycle request. The block then opens a transfer and sends the burst-read command. It turns the data line around and shifts in all eight device registers, least significant bit first. The image is checked for plausibility, and the block returns the seven time fields together with a decoded 24-hour hour value. It reports a valid or an error flag in the same cycle as its completion pulse.

A write request runs two transfers back to back. The first clears the device's write-protect flag. The second bursts the seven host-supplied time bytes and closes with a byte that sets write protection again. All serial timing comes from counters on the system clock: a minimum half period on each clock level, a setup wait between opening a transfer and the first clock edge, and a minimum time the enable line stays low between transfers. After power-on the enable line is low and stays low for the full inactive time before the first request is accepted. The host supplies field bytes already in BCD.

Top module: `tk3w_burst_ctrl`

## Requirements
- R1: While rst_ni is low and afterwards, tk_act_o and tk_sclk_o are low and done_o is low. busy_o stays high until tk_act_o has been low for HOLD_CYC cycles after reset, and only then does it fall.
- R2: Every byte on the data line is sent least significant bit first. A read opens with command 0xBF, and the burst of a write opens with command 0xBE.
- R3: Within a transfer, each high and each low level of tk_sclk_o lasts at least HALF_CYC clock cycles.
- R4: At least SETUP_CYC cycles pass between tk_act_o rising and the first rising edge of tk_sclk_o.
- R5: Once tk_act_o falls, it stays low for at least HOLD_CYC cycles before it rises again.
- R6: A read takes in 64 bits after the command. tk_dat_oe_o is low from the first input bit to the end of the transfer, and changes only while tk_sclk_o is low. Each bit is sampled at the end of its clock-high level. rd_regs_o holds seconds in bits 7:0, then minutes, hours, day of month, month, weekday, and year in bits 55:48.
- R7: A write first runs a 16-bit transfer carrying bytes 0x8E then 0x00. It then runs a 72-bit transfer carrying 0xBE, wr_regs_i bytes 0 to 6 in order (byte 0 in bits 7:0), and 0x80.
- R8: A read image is rejected with error_o in either of two cases. The first is that any of these bits is set: minutes bit 7, hours bit 6, day-of-month bits 7:6, month bits 7:5, weekday bits 7:3, or control-byte bits 6:0. The second is that day of month, month or weekday is zero. On rejection, rd_regs_o and hour_o keep their previous values.
- R9: hour_o gives the hour in binary, 0 to 23. If hours bit 7 is clear, bits 5:0 are a BCD hour. If it is set, bits 4:0 are a BCD hour 1 to 12, 12 maps to 0, and bit 5 adds 12.
- R10: done_o is a one-cycle pulse raised when busy_o falls. On a read it comes with exactly one of valid_o and error_o, and on a write with neither. Start requests are ignored while busy_o is high.
- R11: tk_sclk_o is low whenever tk_act_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_read_i | input | 1 | Request a burst read (wins if both requests are high) |
| start_write_i | input | 1 | Request a protected burst write |
| wr_regs_i | input | 56 | Seven BCD time bytes to write, seconds in bits 7:0 |
| busy_o | output | 1 | Operation in progress, including the power-on hold |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | With done_o: read image accepted |
| error_o | output | 1 | With done_o: read image rejected |
| rd_regs_o | output | 56 | Last accepted time record, seconds in bits 7:0 |
| hour_o | output | 5 | Last accepted hour in binary 24-hour form |
| tk_act_o | output | 1 | Enable line; low holds the device inactive |
| tk_sclk_o | output | 1 | Serial clock |
| tk_dat_o | output | 1 | Serial data out |
| tk_dat_oe_o | output | 1 | Data line drive enable |
| tk_dat_i | input | 1 | Serial data in |

## Verification
A wrong byte or bit counter shows at the device side within one transfer. The captured bit count is off from 8, 16 or 72, or a byte appears shifted or misplaced when decoded LSB first. A wrong turnaround point shows as a drive enable that is high while the device model is presenting read bits. Any slip in the timing counters appears within a single transfer as a shortened clock level, setup or inactive gap. A fault in the sequencer state shows at the host side within one operation: a missing second write transfer, a done pulse without busy falling, or flags leaking into write completion.

// File: rtl/tk3w_pkg.sv
package tk3w_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_LO, ST_HI, ST_HOLD} tk_state_e;

  localparam int REG_N   = 8;  // registers moved by one burst
  localparam int FIELD_N = 7;  // time fields exposed to the host

  localparam logic [7:0] CMD_BURST_WR = 8'hBE;
  localparam logic [7:0] CMD_BURST_RD = 8'hBF;
  localparam logic [7:0] CMD_WP       = 8'h8E;
  localparam logic [7:0] WP_CLR       = 8'h00;
  localparam logic [7:0] WP_SET       = 8'h80;

  localparam logic [3:0] LAST_BURST_BYTE = 4'(REG_N);
  localparam logic [3:0] LAST_WP_BYTE    = 4'd1;
endpackage

// File: rtl/tk3w_timer.sv
module tk3w_timer #(
  parameter int W = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= INIT;
    else if (load_i)      cnt_q <= len_i - W'(1);
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign exp_o = (cnt_q == '0);
endmodule

// File: rtl/tk3w_check.sv
module tk3w_check (
  input  logic [7:0] min_i,
  input  logic [7:0] hour_i,
  input  logic [7:0] mday_i,
  input  logic [7:0] mon_i,
  input  logic [7:0] wday_i,
  input  logic [6:0] ctl_i,
  output logic       ok_o,
  output logic [4:0] hour_o
);
  logic       bad_bits, zero_field;
  logic [4:0] h12, h24;

  always_comb begin
    bad_bits   = min_i[7] | hour_i[6] | (|mday_i[7:6]) | (|mon_i[7:5]) |
                 (|wday_i[7:3]) | (|ctl_i);
    zero_field = (mday_i == 8'd0) | (mon_i == 8'd0) | (wday_i == 8'd0);
    ok_o       = !(bad_bits | zero_field);

    h12 = (hour_i[4] ? 5'd10 : 5'd0) + {1'b0, hour_i[3:0]};
    if (h12 == 5'd12) h12 = 5'd0;
    if (hour_i[5])    h12 = h12 + 5'd12;
    h24 = (hour_i[5] ? 5'd20 : (hour_i[4] ? 5'd10 : 5'd0)) + {1'b0, hour_i[3:0]};

    hour_o = hour_i[7] ? h12 : h24;
  end
endmodule

// File: rtl/tk3w_burst_ctrl.sv
module tk3w_burst_ctrl
  import tk3w_pkg::*;
#(
  parameter int HALF_CYC  = 50,
  parameter int SETUP_CYC = 200,
  parameter int HOLD_CYC  = 200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_read_i,
  input  logic                 start_write_i,
  input  logic [FIELD_N*8-1:0] wr_regs_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 valid_o,
  output logic                 error_o,
  output logic [FIELD_N*8-1:0] rd_regs_o,
  output logic [4:0]           hour_o,
  output logic                 tk_act_o,
  output logic                 tk_sclk_o,
  output logic                 tk_dat_o,
  output logic                 tk_dat_oe_o,
  input  logic                 tk_dat_i
);
  localparam int MAX_A   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_CYC = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam int IMG_W   = REG_N * 8;
  localparam int REC_W   = FIELD_N * 8;

  tk_state_e          state_q;
  logic               is_rd_q, txn_q, run_q;
  logic [3:0]         byte_q;
  logic [2:0]         bit_q;
  logic [REC_W-1:0]   wr_buf_q;
  logic [IMG_W-1:0]   rx_sr_q;
  logic               sclk_q, act_q, done_q, valid_q, err_q;
  logic [REC_W-1:0]   rd_q;
  logic [4:0]         hour_q;

  logic               tmr_load, tmr_exp;
  logic [TW-1:0]      tmr_len;
  logic               start_any, last_bit, rx_phase, more_txn;
  logic [3:0]         last_byte;
  logic [5:0]         sh;
  logic [7:0]         tx_byte;
  logic               chk_ok;
  logic [4:0]         chk_hour;

  assign start_any = start_read_i | start_write_i;
  assign last_byte = (is_rd_q || txn_q) ? LAST_BURST_BYTE : LAST_WP_BYTE;
  assign last_bit  = (bit_q == 3'd7) && (byte_q == last_byte);
  assign rx_phase  = is_rd_q && (byte_q != 4'd0);
  assign more_txn  = run_q && !is_rd_q && !txn_q;
  assign sh        = {byte_q[2:0] - 3'd1, 3'b000};

  always_comb begin
    if (byte_q == 4'd0)             tx_byte = is_rd_q ? CMD_BURST_RD : (txn_q ? CMD_BURST_WR : CMD_WP);
    else if (is_rd_q)               tx_byte = 8'h00;
    else if (!txn_q)                tx_byte = WP_CLR;
    else if (byte_q == last_byte)   tx_byte = WP_SET;
    else                            tx_byte = wr_buf_q[sh +: 8];
  end

  // timer reload on every state entry; length is the duration of the new state
  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = TW'(HALF_CYC);
    unique case (state_q)
      ST_IDLE:  if (start_any) begin tmr_load = 1'b1; tmr_len = TW'(SETUP_CYC); end
      ST_SETUP: if (tmr_exp)   tmr_load = 1'b1;
      ST_LO:    if (tmr_exp)   tmr_load = 1'b1;
      ST_HI:    if (tmr_exp) begin
                  tmr_load = 1'b1;
                  if (last_bit) tmr_len = TW'(HOLD_CYC);
                end
      ST_HOLD:  if (tmr_exp && more_txn) begin tmr_load = 1'b1; tmr_len = TW'(SETUP_CYC); end
      default:  ;
    endcase
  end

  tk3w_timer #(.W(TW), .INIT(TW'(HOLD_CYC - 1))) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .exp_o  (tmr_exp)
  );

  tk3w_check i_check (
    .min_i  (rx_sr_q[15:8]),
    .hour_i (rx_sr_q[23:16]),
    .mday_i (rx_sr_q[31:24]),
    .mon_i  (rx_sr_q[39:32]),
    .wday_i (rx_sr_q[47:40]),
    .ctl_i  (rx_sr_q[62:56]),
    .ok_o   (chk_ok),
    .hour_o (chk_hour)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HOLD;  // power-on inactive hold
      is_rd_q  <= 1'b0;
      txn_q    <= 1'b0;
      run_q    <= 1'b0;
      byte_q   <= '0;
      bit_q    <= '0;
      wr_buf_q <= '0;
      rx_sr_q  <= '0;
      sclk_q   <= 1'b0;
      act_q    <= 1'b0;
      done_q   <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      rd_q     <= '0;
      hour_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_any) begin
          is_rd_q  <= start_read_i;
          txn_q    <= start_read_i;
          run_q    <= 1'b1;
          byte_q   <= '0;
          bit_q    <= '0;
          wr_buf_q <= wr_regs_i;
          act_q    <= 1'b1;
          state_q  <= ST_SETUP;
        end
        ST_SETUP: if (tmr_exp) state_q <= ST_LO;
        ST_LO: if (tmr_exp) begin
          sclk_q  <= 1'b1;
          state_q <= ST_HI;
        end
        ST_HI: if (tmr_exp) begin
          sclk_q <= 1'b0;
          if (rx_phase) rx_sr_q <= {tk_dat_i, rx_sr_q[IMG_W-1:1]};
          if (last_bit) begin
            act_q   <= 1'b0;
            state_q <= ST_HOLD;
          end else begin
            bit_q   <= bit_q + 3'd1;
            if (bit_q == 3'd7) byte_q <= byte_q + 4'd1;
            state_q <= ST_LO;
          end
        end
        ST_HOLD: if (tmr_exp) begin
          if (more_txn) begin
            txn_q   <= 1'b1;
            byte_q  <= '0;
            bit_q   <= '0;
            act_q   <= 1'b1;
            state_q <= ST_SETUP;
          end else begin
            if (run_q) begin
              done_q <= 1'b1;
              if (is_rd_q) begin
                valid_q <= chk_ok;
                err_q   <= !chk_ok;
                if (chk_ok) begin
                  rd_q   <= rx_sr_q[REC_W-1:0];
                  hour_q <= chk_hour;
                end
              end
            end
            run_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign valid_o     = valid_q;
  assign error_o     = err_q;
  assign rd_regs_o   = rd_q;
  assign hour_o      = hour_q;
  assign tk_act_o    = act_q;
  assign tk_sclk_o   = sclk_q;
  assign tk_dat_o    = tx_byte[bit_q];
  assign tk_dat_oe_o = !(rx_phase && (state_q == ST_LO || state_q == ST_HI));
endmodule

// File: rtl/tk3w_burst_ctrl_chk.sv
module tk3w_burst_ctrl_chk #(
  parameter int HALF_CYC  = 50,
  parameter int SETUP_CYC = 200,
  parameter int HOLD_CYC  = 200,
  parameter int REC_W     = 56
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tk_act_o,
  input logic             tk_sclk_o,
  input logic             tk_dat_oe_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             valid_o,
  input logic             error_o,
  input logic [REC_W-1:0] rd_regs_o
);
  logic        sclk_p;
  logic [31:0] lvl_cnt, rel_cnt, low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p  <= 1'b0;
      lvl_cnt <= '0;
      rel_cnt <= '0;
      low_cnt <= '0;
    end else begin
      sclk_p <= tk_sclk_o;
      if (tk_sclk_o != sclk_p)    lvl_cnt <= 32'd1;
      else if (lvl_cnt != '1)     lvl_cnt <= lvl_cnt + 32'd1;
      if (!tk_act_o)              rel_cnt <= '0;
      else if (rel_cnt != '1)     rel_cnt <= rel_cnt + 32'd1;
      if (tk_act_o)               low_cnt <= '0;
      else if (low_cnt != '1)     low_cnt <= low_cnt + 32'd1;
    end
  end

  p_sclk_low_when_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tk_act_o |-> !tk_sclk_o);

  p_half_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tk_sclk_o != sclk_p) |-> (lvl_cnt >= 32'(HALF_CYC)));

  p_setup_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tk_sclk_o) |-> (rel_cnt >= 32'(SETUP_CYC)));

  p_inactive_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tk_act_o) |-> (low_cnt >= 32'(HOLD_CYC)));

  p_turn_while_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tk_dat_oe_o != $past(tk_dat_oe_o)) |-> !tk_sclk_o);

  p_regs_only_on_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(rd_regs_o));

  p_flags_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && error_o));

  p_flags_need_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || error_o) |-> done_o);

  p_done_ends_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $fell(busy_o)));
endmodule

bind tk3w_burst_ctrl tk3w_burst_ctrl_chk #(
  .HALF_CYC  (HALF_CYC),
  .SETUP_CYC (SETUP_CYC),
  .HOLD_CYC  (HOLD_CYC),
  .REC_W     (FIELD_N*8)
) i_tk3w_burst_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tk_act_o    (tk_act_o),
  .tk_sclk_o   (tk_sclk_o),
  .tk_dat_oe_o (tk_dat_oe_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .valid_o     (valid_o),
  .error_o     (error_o),
  .rd_regs_o   (rd_regs_o)
);

// File: tb/test_tk3w_burst_ctrl.sv
module test_tk3w_burst_ctrl;
  localparam int HALF  = 3;
  localparam int SETUP = 8;
  localparam int HOLD  = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_read = 1'b0, start_write = 1'b0;
  logic [55:0] wr_regs = '0;
  logic        busy, done, valid, error;
  logic [55:0] rd_regs;
  logic [4:0]  hour;
  logic        act, sclk, dat_o, dat_oe, dat_i;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  tk3w_burst_ctrl #(.HALF_CYC(HALF), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) i_tk3w_burst_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_read_i(start_read), .start_write_i(start_write),
    .wr_regs_i(wr_regs), .busy_o(busy), .done_o(done), .valid_o(valid), .error_o(error),
    .rd_regs_o(rd_regs), .hour_o(hour), .tk_act_o(act), .tk_sclk_o(sclk),
    .tk_dat_o(dat_o), .tk_dat_oe_o(dat_oe), .tk_dat_i(dat_i));

  // device model and line monitor, sampled on the falling clock edge
  logic [63:0]  img = '0;
  logic [127:0] cap_v = '0;
  logic [127:0] log_v [0:31];
  int           log_n [0:31];
  int           ntxn = 0, nbits = 0, rc = 0;
  logic         en_p = 1'b0, sclk_p = 1'b0, first_rise = 1'b0;
  int           lvl = 0, min_half = 1000000, sc = 0, setup_min = 1000000;
  int           hc = 0, hold_min = 1000000, oe_bad = 0, idle_clk = 0;

  always_comb dat_i = (rc >= 9 && rc <= 72) ? img[rc-9] : 1'b0;

  always @(negedge clk) begin
    if (!act && sclk) idle_clk++;
    if (act && !en_p) begin
      nbits = 0; rc = 0; cap_v = '0; first_rise = 1'b1;
      if (hc < hold_min) hold_min = hc;
      sc = 0;
    end
    if (!act) hc++;
    else sc++;
    if (sclk != sclk_p) begin
      if (act && en_p && lvl < min_half) min_half = lvl;
      lvl = 1;
    end else lvl++;
    if (act && sclk && !sclk_p) begin
      if (first_rise) begin
        if (sc < setup_min) setup_min = sc;
        first_rise = 1'b0;
      end
      rc++;
      if (rc <= 8 && !dat_oe) oe_bad++;
      if (rc > 8 && cap_v[7:0] == 8'hBF && dat_oe) oe_bad++;
      if (dat_oe) begin
        cap_v[nbits] = dat_o;
        nbits++;
      end
    end
    if (!act && en_p) begin
      log_v[ntxn] = cap_v; log_n[ntxn] = nbits; ntxn++; hc = 1;
    end
    en_p = act; sclk_p = sclk;
  end

  task automatic chk(input logic ok, input string req, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic wait_done(output logic v, output logic e);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done, "R10 done timeout", 0, 1);
    chk(!busy, "R10 busy low with done", busy, 0);
    v = valid; e = error;
  endtask

  task automatic do_read(input logic [63:0] image, output logic v, output logic e);
    img = image;
    @(negedge clk) start_read = 1'b1;
    @(negedge clk) start_read = 1'b0;
    chk(busy, "R10 busy after start", busy, 1);
    wait_done(v, e);
  endtask

  function automatic logic [63:0] mk(input logic [7:0] s, mi, h, md, mo, wd, y, c);
    return {c, y, wd, mo, md, h, mi, s};
  endfunction

  task automatic t_reset;
    chk(!act && !sclk && !done, "R1 in reset", {act, sclk, done}, 0);
    @(negedge clk) rst_ni = 1'b1;
    chk(busy && !act, "R1 power-on hold busy", {busy, act}, 2'b10);
    repeat (HOLD + 3) @(negedge clk);
    chk(!busy && !act && !sclk, "R1 hold released", {busy, act, sclk}, 0);
  endtask

  task automatic t_read_valid;
    logic v, e;
    logic [63:0] im = mk(8'h59, 8'h30, 8'h23, 8'h31, 8'h12, 8'h07, 8'h99, 8'h80);
    int k = ntxn;
    do_read(im, v, e);
    chk(v && !e, "R10 read valid flag", {v, e}, 2'b10);
    chk(log_n[k] == 8, "R2 read command bit count", log_n[k], 8);
    chk(log_v[k][7:0] == 8'hBF, "R2 read command LSB first", log_v[k][7:0], 8'hBF);
    chk(rd_regs == im[55:0], "R6 field order", rd_regs, im[55:0]);
    chk(hour == 5'd23, "R9 24h hour", hour, 23);
    chk(oe_bad == 0, "R6 data-line turnaround", oe_bad, 0);
  endtask

  task automatic t_read_12h(input logic [7:0] h, input logic [4:0] exp_h);
    logic v, e;
    do_read(mk(8'h00, 8'h01, h, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00), v, e);
    chk(v, "R9 12h image accepted", v, 1);
    chk(hour == exp_h, "R9 12h decode", hour, exp_h);
  endtask

  task automatic t_read_bad(input logic [63:0] im);
    logic v, e;
    logic [55:0] prev = rd_regs;
    logic [4:0]  ph = hour;
    do_read(im, v, e);
    chk(e && !v, "R8 error flag", {v, e}, 2'b01);
    chk(rd_regs == prev && hour == ph, "R8 regs kept", rd_regs, prev);
  endtask

  task automatic t_write;
    logic v, e;
    logic [55:0] w = {8'h24, 8'h03, 8'h06, 8'h15, 8'h08, 8'h45, 8'h10};
    logic [71:0] exp_b = {8'h80, w, 8'hBE};
    int k = ntxn;
    wr_regs = w;
    @(negedge clk) start_write = 1'b1;
    @(negedge clk) begin start_write = 1'b0; wr_regs = '1; end
    wait_done(v, e);
    chk(!v && !e, "R10 write has no flags", {v, e}, 0);
    chk(ntxn == k + 2, "R7 two transfers", ntxn - k, 2);
    chk(log_n[k] == 16 && log_v[k][15:0] == 16'h008E, "R7 protect release", log_v[k][15:0], 16'h008E);
    chk(log_n[k+1] == 72, "R7 burst length", log_n[k+1], 72);
    chk(log_v[k+1][71:0] == exp_b, "R2 R7 burst bytes", log_v[k+1][63:0], exp_b[63:0]);
  endtask

  task automatic t_busy_ignore;
    logic v, e;
    int k = ntxn;
    img = mk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h80);
    @(negedge clk) start_read = 1'b1;
    @(negedge clk) start_read = 1'b0;
    repeat (20) @(negedge clk);
    start_write = 1'b1; start_read = 1'b1;
    @(negedge clk) begin start_write = 1'b0; start_read = 1'b0; end
    wait_done(v, e);
    repeat (HOLD + SETUP + 10) @(negedge clk);
    chk(ntxn == k + 1 && !busy, "R10 start ignored while busy", ntxn - k, 1);
  endtask

  task automatic t_timing;
    chk(min_half >= HALF, "R3 half period", min_half, HALF);
    chk(setup_min >= SETUP, "R4 setup wait", setup_min, SETUP);
    chk(hold_min >= HOLD, "R5 inactive hold", hold_min, HOLD);
    chk(idle_clk == 0, "R11 clock low while inactive", idle_clk, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_read_valid();
    t_read_12h(8'h92, 5'd0);
    t_read_12h(8'hB1, 5'd23);
    t_read_12h(8'hB2, 5'd12);
    t_read_12h(8'h81, 5'd1);
    t_read_valid();
    t_read_bad(mk(8'h00, 8'hB0, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00, 8'h80));
    t_read_bad(mk(8'h00, 8'h10, 8'h10, 8'h01, 8'h00, 8'h01, 8'h00, 8'h80));
    t_read_bad(mk(8'h00, 8'h10, 8'h10, 8'h01, 8'h01, 8'h08, 8'h00, 8'h80));
    t_read_bad(mk(8'h00, 8'h10, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00, 8'h81));
    t_read_bad(mk(8'h00, 8'h10, 8'h50, 8'h01, 8'h01, 8'h01, 8'h00, 8'h80));
    t_write();
    t_busy_ignore();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule